// File: doc/BRIEF.md
# Byte-Opcode Stack Execution Core

A small execution core for a threaded, stack-oriented language. Every instruction is a single byte fetched from a byte-addressed program memory at the instruction pointer. The byte's value selects the operation directly; no lookup table sits between fetch and execute. The operations act on a data stack and a return stack, each held in registers inside the core. The memory port has one cycle of read latency, so each instruction takes one fetch cycle and one execute cycle.

The implemented set covers these operations:
- single-byte pushes of small constants, which all share one cascaded accumulator chain;
- exchange of the two top entries, addition, and discard;
- a return through the return stack;
- a move from the data stack to the return stack, which gives a return somewhere to go;
- a no-op.

Any other byte, and any stack overflow or underflow, stops the core with a sticky flag and leaves its state intact for inspection. Debug outputs expose the instruction pointer, the top of the data stack and both stack depths.

Top module: `stk_core`

## Requirements
- R1: While reset is high at a clock edge, the IP is loaded from `start_addr_i`. Both stack depths become 0, both fault flags clear, and `dbg_tos_o` reads 0.
- R2: Each instruction is one byte and takes two cycles. `mem_addr_o` shows the IP during the fetch cycle. The opcode on `mem_data_i` is consumed one cycle later. A completed non-return instruction leaves IP+1.
- R3: The constant opcodes push one entry and take no operand byte: 0x75→32, 0x76→16, 0x77→8, 0x78→4, 0x79→2, 0x7A→1, 0x7B→3, 0x7C→0xFFFF, 0x7D→0.
- R4: Opcode 0x1F exchanges the top two data-stack entries. Two in a row leave the stack as it was.
- R5: Opcode 0x27 replaces the top two data-stack entries with their sum modulo 2^16, so the depth drops by one.
- R6: Opcode 0x11 removes the top data-stack entry.
- R7: Opcode 0x0F pops the top data-stack entry and pushes it onto the return stack.
- R8: Opcode 0x0C pops the return stack into the IP, and fetching continues from that address.
- R9: Opcode 0x0E changes only the IP, which advances by one.
- R10: An opcode outside the set above sets `ill_op_o`. The core then stops with the IP on the offending byte and stack depths unchanged, until reset.
- R11: A push onto a full stack (16 entries) or a pop from a stack with too few entries sets `stk_err_o`. The core then stops with the IP on the offending byte and both stacks unchanged, until reset.
- R12: While `halt_i` is high, the core waits between instructions and its IP and stack depths do not change. Execution resumes when `halt_i` falls.
- R13: `dbg_tos_o` reads 0 whenever the data stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr_i | input | 16 | IP value loaded during reset |
| halt_i | input | 1 | Hold the core between instructions |
| mem_addr_o | output | 16 | Program memory byte address |
| mem_data_i | input | 8 | Program memory byte, valid one cycle after the address |
| dbg_ip_o | output | 16 | Current instruction pointer |
| dbg_tos_o | output | 16 | Top data-stack entry, 0 when empty |
| dbg_dsp_o | output | 5 | Data-stack depth |
| dbg_rsp_o | output | 5 | Return-stack depth |
| stk_err_o | output | 1 | Sticky stack overflow/underflow fault |
| ill_op_o | output | 1 | Sticky illegal-opcode fault |

## Verification
Several short programs each start from their own reset address:
- One runs every constant opcode back to back, which separates the cascaded chain's nine values from one another.
- One builds a return address from two constants and moves it to the return stack. It then runs the push/push/exchange/exchange/add/return sequence, which shows that a double exchange is neutral and that the return lands on the computed address.
- One adds two all-ones constants and then exchanges and discards, which exposes carry wrap and exchange order.
- Separate runs fill each stack past its depth, underflow the adder, return on an empty return stack, and pause mid-program with the halt input. These tell correct fault placement and freezing apart from off-by-one pointer errors.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_FAULT = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        SOP_NONE  = 3'd0,
        SOP_PUSH  = 3'd1,
        SOP_POP   = 3'd2,
        SOP_SWAP  = 3'd3,
        SOP_POPWR = 3'd4
    } sop_e;

    localparam logic [7:0] OPC_EXIT   = 8'h0C;
    localparam logic [7:0] OPC_NOP    = 8'h0E;
    localparam logic [7:0] OPC_TOR    = 8'h0F;
    localparam logic [7:0] OPC_DROP   = 8'h11;
    localparam logic [7:0] OPC_SWAP   = 8'h1F;
    localparam logic [7:0] OPC_PLUS   = 8'h27;
    localparam logic [7:0] OPC_K_BASE = 8'h75;
    localparam logic [7:0] OPC_K_TRUE = 8'h7C;
    localparam logic [7:0] OPC_K_ZERO = 8'h7D;

    // Number of cascaded stages ahead of the shared decrement.
    localparam int K_STAGES = 7;

    // Stage i yields (value + 1), and the decrement at the end removes the 1.
    function automatic int k_stage_val(input int i);
        case (i)
            0:       return 32;
            1:       return 16;
            2:       return 8;
            3:       return 4;
            4:       return 2;
            5:       return 1;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/stk_konst.sv
module stk_konst
    import stk_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [7:0]   op_i,
    output logic [W-1:0] val_o
);
    logic [W-1:0] acc;
    logic         taken;

    // The accumulator starts at zero. The first stage whose code is not below
    // the opcode loads (value + 1) and blocks every later stage. If no stage
    // takes it, the accumulator stays zero, giving TRUE after the decrement.
    always_comb begin
        acc   = '0;
        taken = 1'b0;
        for (int i = 0; i < K_STAGES; i++) begin
            if (!taken && (op_i <= OPC_K_BASE + 8'(i))) begin
                acc   = W'(k_stage_val(i) + 1);
                taken = 1'b1;
            end
        end
        val_o = (op_i == OPC_K_ZERO) ? acc : acc - W'(1);
    end
endmodule

// File: rtl/stk_lifo.sv
module stk_lifo
    import stk_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  sop_e                       op_i,
    input  logic [W-1:0]               din_i,
    output logic [W-1:0]               top_o,
    output logic [W-1:0]               nxt_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [W-1:0]  mem_d [DEPTH];
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] c_m1, c_m2;
    logic [PW-1:0] i_top, i_nxt, i_new;

    assign c_m1  = cnt_q - CW'(1);
    assign c_m2  = cnt_q - CW'(2);
    assign i_top = c_m1[PW-1:0];
    assign i_nxt = c_m2[PW-1:0];
    assign i_new = cnt_q[PW-1:0];

    assign top_o = (cnt_q != '0)      ? mem_q[i_top] : '0;
    assign nxt_o = (cnt_q >= CW'(2))  ? mem_q[i_nxt] : '0;
    assign cnt_o = cnt_q;

    // The caller only requests operations that are legal for the current depth.
    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        case (op_i)
            SOP_PUSH: begin
                mem_d[i_new] = din_i;
                cnt_d        = cnt_q + CW'(1);
            end
            SOP_POP: cnt_d = c_m1;
            SOP_SWAP: begin
                mem_d[i_top] = mem_q[i_nxt];
                mem_d[i_nxt] = mem_q[i_top];
            end
            SOP_POPWR: begin
                mem_d[i_nxt] = din_i;
                cnt_d        = c_m1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
        mem_q <= mem_d;
    end
endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [AW-1:0]               start_addr_i,
    input  logic                        halt_i,
    output logic [AW-1:0]               mem_addr_o,
    input  logic [7:0]                  mem_data_i,
    output logic [AW-1:0]               dbg_ip_o,
    output logic [DW-1:0]               dbg_tos_o,
    output logic [$clog2(DEPTH+1)-1:0]  dbg_dsp_o,
    output logic [$clog2(DEPTH+1)-1:0]  dbg_rsp_o,
    output logic                        stk_err_o,
    output logic                        ill_op_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] ip;
        logic          stk_err;
        logic          ill;
    } core_t;

    core_t core_q, core_d;

    sop_e          ds_op, rs_op;
    logic [DW-1:0] ds_din, rs_din;
    logic [DW-1:0] ds_top, ds_nxt, rs_top, rs_nxt;
    logic [CW-1:0] ds_cnt, rs_cnt;
    logic [DW-1:0] k_val;
    logic          bad_depth;

    stk_lifo #(.W(DW), .DEPTH(DEPTH)) u_dstk (
        .clk(clk), .rst(rst), .op_i(ds_op), .din_i(ds_din),
        .top_o(ds_top), .nxt_o(ds_nxt), .cnt_o(ds_cnt)
    );

    stk_lifo #(.W(DW), .DEPTH(DEPTH)) u_rstk (
        .clk(clk), .rst(rst), .op_i(rs_op), .din_i(rs_din),
        .top_o(rs_top), .nxt_o(rs_nxt), .cnt_o(rs_cnt)
    );

    stk_konst #(.W(DW)) u_konst (
        .op_i(mem_data_i), .val_o(k_val)
    );

    always_comb begin
        core_d    = core_q;
        ds_op     = SOP_NONE;
        rs_op     = SOP_NONE;
        ds_din    = '0;
        rs_din    = '0;
        bad_depth = 1'b0;
        case (core_q.ph)
            PH_FETCH: if (!halt_i) core_d.ph = PH_EXEC;
            PH_EXEC: begin
                core_d.ph = PH_FETCH;
                core_d.ip = core_q.ip + AW'(1);
                case (mem_data_i) inside
                    OPC_NOP: ;
                    OPC_EXIT: begin
                        if (rs_cnt == '0) bad_depth = 1'b1;
                        else begin
                            rs_op     = SOP_POP;
                            core_d.ip = AW'(rs_top);
                        end
                    end
                    OPC_TOR: begin
                        if (ds_cnt == '0 || rs_cnt == FULL) bad_depth = 1'b1;
                        else begin
                            ds_op  = SOP_POP;
                            rs_op  = SOP_PUSH;
                            rs_din = ds_top;
                        end
                    end
                    OPC_DROP: begin
                        if (ds_cnt == '0) bad_depth = 1'b1;
                        else ds_op = SOP_POP;
                    end
                    OPC_SWAP: begin
                        if (ds_cnt < CW'(2)) bad_depth = 1'b1;
                        else ds_op = SOP_SWAP;
                    end
                    OPC_PLUS: begin
                        // Addition finishes through the discard path, writing the sum below.
                        if (ds_cnt < CW'(2)) bad_depth = 1'b1;
                        else begin
                            ds_op  = SOP_POPWR;
                            ds_din = ds_top + ds_nxt;
                        end
                    end
                    [OPC_K_BASE:OPC_K_ZERO]: begin
                        if (ds_cnt == FULL) bad_depth = 1'b1;
                        else begin
                            ds_op  = SOP_PUSH;
                            ds_din = k_val;
                        end
                    end
                    default: begin
                        core_d.ph  = PH_FAULT;
                        core_d.ill = 1'b1;
                        core_d.ip  = core_q.ip;
                    end
                endcase
                if (bad_depth) begin
                    core_d.ph      = PH_FAULT;
                    core_d.stk_err = 1'b1;
                    core_d.ip      = core_q.ip;
                    ds_op          = SOP_NONE;
                    rs_op          = SOP_NONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q.ph      <= PH_FETCH;
            core_q.ip      <= start_addr_i;
            core_q.stk_err <= 1'b0;
            core_q.ill     <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign mem_addr_o = core_q.ip;
    assign dbg_ip_o   = core_q.ip;
    assign dbg_tos_o  = ds_top;
    assign dbg_dsp_o  = ds_cnt;
    assign dbg_rsp_o  = rs_cnt;
    assign stk_err_o  = core_q.stk_err;
    assign ill_op_o   = core_q.ill;
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk
    import stk_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       halt_i,
    input logic [7:0]                 op,
    input phase_e                     ph,
    input logic [AW-1:0]              ip,
    input logic [$clog2(DEPTH+1)-1:0] ds_cnt,
    input logic [$clog2(DEPTH+1)-1:0] rs_cnt,
    input logic [DW-1:0]              rs_top,
    input logic [DW-1:0]              rs_nxt,
    input logic                       stk_err,
    input logic                       ill
);
    localparam int CW = $clog2(DEPTH + 1);

    AST_FETCH_HOLDS_IP: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FETCH) |=> (ip == $past(ip)));                                   // R2
    AST_NOP_STEP: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_EXEC && op == OPC_NOP) |=> (ip == $past(ip) + AW'(1) && $stable(ds_cnt))); // R9
    AST_EXIT_LOADS_IP: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_EXEC && op == OPC_EXIT && rs_cnt != '0)
        |=> (ip == AW'($past(rs_top)) && rs_cnt == $past(rs_cnt) - CW'(1)));      // R8
    AST_EXIT_EXPOSES_NEXT: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_EXEC && op == OPC_EXIT && rs_cnt >= CW'(2))
        |=> (rs_top == $past(rs_nxt)));                                            // R8
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_FETCH && halt_i)
        |=> ($stable(ip) && $stable(ds_cnt) && $stable(rs_cnt) && ph == PH_FETCH)); // R12
    AST_FAULT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (stk_err || ill) |=> ($stable(ip) && $stable(ds_cnt) && $stable(rs_cnt)));  // R10
    AST_STK_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        stk_err |=> stk_err);                                                      // R11
    AST_ILL_STICKY: assert property (@(posedge clk) disable iff (rst)
        ill |=> ill);                                                              // R10
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        (ds_cnt <= CW'(DEPTH) && rs_cnt <= CW'(DEPTH)));                           // R11
endmodule

bind stk_core stk_core_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .halt_i(halt_i), .op(mem_data_i),
    .ph(core_q.ph), .ip(core_q.ip), .ds_cnt(ds_cnt), .rs_cnt(rs_cnt),
    .rs_top(rs_top), .rs_nxt(rs_nxt), .stk_err(core_q.stk_err), .ill(core_q.ill)
);

// File: tb/tb_stk_core.sv
module tb_stk_core;
    localparam int AW = 16, DW = 16, DEPTH = 16, CW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          halt = 1'b0;
    logic [AW-1:0] start = '0;
    logic [AW-1:0] maddr, dip;
    logic [7:0]    mdata = 8'h00;
    logic [DW-1:0] dtos;
    logic [CW-1:0] dsp, rsp;
    logic          serr, ill;

    logic [7:0] prog [256];
    int n_tests = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    // Program memory with one cycle of read latency.
    always @(posedge clk) mdata <= prog[maddr[7:0]];

    stk_core #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .start_addr_i(start), .halt_i(halt),
        .mem_addr_o(maddr), .mem_data_i(mdata), .dbg_ip_o(dip),
        .dbg_tos_o(dtos), .dbg_dsp_o(dsp), .dbg_rsp_o(rsp),
        .stk_err_o(serr), .ill_op_o(ill)
    );

    // Behavioural reference model.
    int          m_ph = 0;     // 0 fetch, 1 execute, 2 stopped
    logic [15:0] m_ip = '0;
    logic [15:0] m_ds[$];
    logic [15:0] m_rs[$];
    bit          m_se = 0, m_ill = 0, m_live = 0;

    function automatic logic [15:0] kval(input logic [7:0] op);
        case (op)
            8'h75: return 16'd32;
            8'h76: return 16'd16;
            8'h77: return 16'd8;
            8'h78: return 16'd4;
            8'h79: return 16'd2;
            8'h7A: return 16'd1;
            8'h7B: return 16'd3;
            8'h7C: return 16'hFFFF;
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [7:0]  op;
        logic [15:0] a, b;
        bit          bad;
        if (rst) begin
            m_ph = 0; m_ip = start; m_ds.delete(); m_rs.delete();
            m_se = 0; m_ill = 0; m_live = 1;
        end else if (m_ph == 0) begin
            if (!halt) m_ph = 1;
        end else if (m_ph == 1) begin
            op = prog[m_ip[7:0]];
            bad = 0;
            m_ph = 0;
            case (op)
                8'h0E: m_ip++;
                8'h0C: if (m_rs.size() == 0) bad = 1; else m_ip = m_rs.pop_back();
                8'h0F: if (m_ds.size() == 0 || m_rs.size() >= DEPTH) bad = 1;
                       else begin m_rs.push_back(m_ds.pop_back()); m_ip++; end
                8'h11: if (m_ds.size() == 0) bad = 1; else begin void'(m_ds.pop_back()); m_ip++; end
                8'h1F: if (m_ds.size() < 2) bad = 1;
                       else begin a = m_ds.pop_back(); b = m_ds.pop_back();
                                  m_ds.push_back(a); m_ds.push_back(b); m_ip++; end
                8'h27: if (m_ds.size() < 2) bad = 1;
                       else begin a = m_ds.pop_back(); b = m_ds.pop_back();
                                  m_ds.push_back(a + b); m_ip++; end
                8'h75, 8'h76, 8'h77, 8'h78, 8'h79, 8'h7A, 8'h7B, 8'h7C, 8'h7D:
                       if (m_ds.size() >= DEPTH) bad = 1;
                       else begin m_ds.push_back(kval(op)); m_ip++; end
                default: begin m_ill = 1; m_ph = 2; end
            endcase
            if (bad) begin m_se = 1; m_ph = 2; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (m_live && !rst) begin
            chk("R2 ip vs model", 32'(dip), 32'(m_ip));
            chk("R2 mem_addr vs model", 32'(maddr), 32'(m_ip));
            chk("R3 R4 R5 R6 R13 tos vs model", 32'(dtos),
                32'((m_ds.size() != 0) ? m_ds[m_ds.size() - 1] : 16'h0));
            chk("R5 R6 R7 dsp vs model", 32'(dsp), 32'(m_ds.size()));
            chk("R7 R8 rsp vs model", 32'(rsp), 32'(m_rs.size()));
            chk("R11 stk_err vs model", 32'(serr), 32'(m_se));
            chk("R10 ill vs model", 32'(ill), 32'(m_ill));
        end
        if (cyc > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic start_at(input logic [AW-1:0] a);
        @(negedge clk); rst = 1'b1; start = a;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic run_to_stop(input int max);
        for (int i = 0; i < max && !(serr || ill); i++) @(negedge clk);
    endtask

    initial begin
        logic [AW-1:0] ip_h;
        logic [CW-1:0] d_h;
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        // Return address 48 built from constants, moved to the return stack, then the demo sequence.
        prog[8'h00] = 8'h75; prog[8'h01] = 8'h76; prog[8'h02] = 8'h27; prog[8'h03] = 8'h0F;
        prog[8'h04] = 8'h7A; prog[8'h05] = 8'h79; prog[8'h06] = 8'h1F; prog[8'h07] = 8'h1F;
        prog[8'h08] = 8'h27; prog[8'h09] = 8'h0C;
        prog[8'h30] = 8'h7B; prog[8'h31] = 8'h7C; prog[8'h32] = 8'h7D; prog[8'h33] = 8'h78;
        prog[8'h34] = 8'h77; prog[8'h35] = 8'h0E; prog[8'h36] = 8'h11; // 0x37 illegal
        for (int i = 0; i < 9; i++) prog[8'h40 + i] = 8'h75 + 8'(i);  // all constants, 0x49 illegal
        for (int i = 0; i < 17; i++) prog[8'h50 + i] = 8'h7A;         // overflow at 0x60
        prog[8'h80] = 8'h7A; prog[8'h81] = 8'h27;                      // underflow at 0x81
        prog[8'h90] = 8'h0C;                                           // empty return
        prog[8'hA0] = 8'h79; prog[8'hA1] = 8'h79; prog[8'hA2] = 8'h27; prog[8'hA3] = 8'h79;
        prog[8'hA4] = 8'h27; prog[8'hA5] = 8'h0E;                      // 0xA6 illegal
        prog[8'hB0] = 8'h7C; prog[8'hB1] = 8'h7C; prog[8'hB2] = 8'h27; prog[8'hB3] = 8'h7A;
        prog[8'hB4] = 8'h1F; prog[8'hB5] = 8'h11;                      // 0xB6 illegal
        for (int i = 0; i < 17; i++) begin
            prog[8'hC0 + 8'(2 * i)]     = 8'h7A;
            prog[8'hC0 + 8'(2 * i + 1)] = 8'h0F;                       // fault at 0xE1
        end

        repeat (3) @(negedge clk);
        // R1: reset state
        start_at(16'h0000);
        chk("R1 ip after reset", 32'(dip), 32'h0);
        chk("R1 dsp after reset", 32'(dsp), 32'h0);
        chk("R1 rsp after reset", 32'(rsp), 32'h0);
        chk("R1 tos after reset", 32'(dtos), 32'h0);
        chk("R1 flags after reset", 32'({serr, ill}), 32'h0);
        run_to_stop(200);
        chk("R8 R10 ip at illegal byte after return", 32'(dip), 32'h37);
        chk("R10 ill flag", 32'(ill), 32'h1);
        chk("R3 R6 depth after constants and drop", 32'(dsp), 32'd5);
        chk("R6 tos after drop", 32'(dtos), 32'd4);
        chk("R8 return stack emptied", 32'(rsp), 32'd0);
        repeat (4) @(negedge clk);
        chk("R10 ip frozen", 32'(dip), 32'h37);

        start_at(16'h0040);
        run_to_stop(200);
        chk("R3 all nine constants pushed", 32'(dsp), 32'd9);
        chk("R3 FALSE on top", 32'(dtos), 32'd0);
        chk("R10 ip on illegal", 32'(dip), 32'h49);

        start_at(16'h0050);
        run_to_stop(200);
        chk("R11 overflow flag", 32'(serr), 32'h1);
        chk("R11 overflow ip", 32'(dip), 32'h60);
        chk("R11 overflow depth", 32'(dsp), 32'd16);
        chk("R11 no ill on overflow", 32'(ill), 32'h0);

        start_at(16'h0080);
        run_to_stop(200);
        chk("R11 underflow ip", 32'(dip), 32'h81);
        chk("R11 underflow keeps stack", 32'(dsp), 32'd1);
        chk("R11 underflow keeps tos", 32'(dtos), 32'd1);

        start_at(16'h0090);
        run_to_stop(200);
        chk("R11 R8 empty return faults", 32'(serr), 32'h1);
        chk("R11 ip held on return", 32'(dip), 32'h90);
        chk("R13 tos zero when empty", 32'(dtos), 32'h0);

        start_at(16'h00A0);
        repeat (3) @(negedge clk);
        halt = 1'b1;
        repeat (2) @(negedge clk);
        ip_h = dip; d_h = dsp;
        repeat (8) @(negedge clk);
        chk("R12 ip frozen under halt", 32'(dip), 32'(ip_h));
        chk("R12 depth frozen under halt", 32'(dsp), 32'(d_h));
        halt = 1'b0;
        run_to_stop(200);
        chk("R5 R12 sum after resume", 32'(dtos), 32'd6);
        chk("R9 R12 ip after resume", 32'(dip), 32'hA6);

        start_at(16'h00B0);
        run_to_stop(200);
        chk("R4 swap order then drop", 32'(dtos), 32'd1);
        chk("R5 R6 depth", 32'(dsp), 32'd1);

        start_at(16'h00C0);
        run_to_stop(400);
        chk("R7 R11 return stack full", 32'(rsp), 32'd16);
        chk("R7 R11 fault ip", 32'(dip), 32'hE1);
        chk("R7 data left", 32'(dsp), 32'd1);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule